// File: doc/BRIEF.md
# Four-Function Ripple ALU

This block is a purely combinational arithmetic and logic unit for two operands of a configurable width. A 2-bit operation code picks one of four results: the sum, the difference, the bitwise AND or the bitwise OR of the two operands. Both arithmetic operations share one ripple chain of 1-bit full adders. For subtraction, each bit of the second operand is inverted by an XOR gate that takes the subtract control as its other input. The same control also sets the chain's carry-in to 1, which completes the two's-complement negation.

Besides the selected result, the block reports the unsigned carry-out of the top adder stage and a signed-overflow flag. The overflow flag is the XOR of the carry into and the carry out of the top stage. Both flags are forced low for the two logic operations. The block has no clock and no state. A datapath instantiates it between its operand registers and its writeback register. The operation code comes straight from instruction decode.

Top module: `alu4_ripple`

## Requirements
- R1: With op_sel = 2'b00 (add), result equals (opnd_a + opnd_b) modulo 2^WIDTH.
- R2: With op_sel = 2'b01 (subtract), result equals (opnd_a - opnd_b) modulo 2^WIDTH.
- R3: With op_sel = 2'b10, result equals opnd_a AND opnd_b, bit by bit.
- R4: With op_sel = 2'b11, result equals opnd_a OR opnd_b, bit by bit.
- R5: For add, carry_out equals bit WIDTH of the unsigned (WIDTH+1)-bit sum of the operands.
- R6: For subtract, carry_out is 1 exactly when opnd_a is greater than or equal to opnd_b as unsigned numbers, so no borrow occurs.
- R7: For add, overflow is 1 exactly when both operands have the same sign bit (bit WIDTH-1) and the result's sign bit differs from it.
- R8: For subtract, overflow is 1 exactly when the operands' sign bits differ and the result's sign bit differs from opnd_a's sign bit.
- R9: For op_sel 2'b10 and 2'b11, carry_out and overflow are both 0, whatever the operands are.
- R10: carry_out and overflow are independent signals. Adding all-ones to all-ones gives carry_out 1 with overflow 0. Adding 1 to the largest positive value gives carry_out 0 with overflow 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (subtrahend for subtract) |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Unsigned carry out of the top adder stage; 0 for logic operations |
| overflow | output | 1 | Signed overflow of add or subtract; 0 for logic operations |

## Verification
The bench builds two copies of the block. The first uses the default WIDTH of 32 and runs directed corner operands plus a seeded random sweep, so the sign-boundary values 0x7FFFFFFF, 0x80000000 and all-ones reach the long carry chain. The second uses WIDTH = 4 and is driven through every operand pair with every operation code. At that width the carry and overflow rules are covered exhaustively, including every case where the top-stage carry-in and carry-out disagree.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_e;

endpackage

// File: rtl/alu4_fa.sv
module alu4_fa (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);

    logic half;

    always_comb begin
        half  = x_in ^ y_in;
        s_out = half ^ c_in;
        c_out = (x_in & y_in) | (half & c_in);
    end

endmodule

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             sub_en,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_top,
    output logic             v_top
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] y_cond;

    assign chain[0] = sub_en;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign y_cond[i] = y_in[i] ^ sub_en;
        alu4_fa u_fa (
            .x_in  (x_in[i]),
            .y_in  (y_cond[i]),
            .c_in  (chain[i]),
            .s_out (sum_out[i]),
            .c_out (chain[i+1])
        );
    end

    assign c_top = chain[WIDTH];
    assign v_top = chain[WIDTH] ^ chain[TOP];

    always_comb begin
        AST_SIGN_RULE: assert (v_top == ((x_in[TOP] == y_cond[TOP]) && (sum_out[TOP] != x_in[TOP]))) // R7
            else $error("overflow disagrees with sign rule");
    end

endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             pick_or,
    output logic [WIDTH-1:0] y_out
);

    always_comb begin
        if (pick_or) y_out = x_in | y_in;
        else         y_out = x_in & y_in;
    end

endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple
    import alu4_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);

    alu_op_e          op;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic             arith_c;
    logic             arith_v;

    assign op = alu_op_e'(op_sel);

    alu4_addsub #(.WIDTH(WIDTH)) u_addsub (
        .x_in    (opnd_a),
        .y_in    (opnd_b),
        .sub_en  (op_sel[0]),
        .sum_out (arith_res),
        .c_top   (arith_c),
        .v_top   (arith_v)
    );

    alu4_logic #(.WIDTH(WIDTH)) u_logic (
        .x_in    (opnd_a),
        .y_in    (opnd_b),
        .pick_or (op_sel[0]),
        .y_out   (logic_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: begin
                result    = arith_res;
                carry_out = arith_c;
                overflow  = arith_v;
            end
            default: begin
                result    = logic_res;
                carry_out = 1'b0;
                overflow  = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (op == OP_ADD) begin
            AST_ADD_SUM: assert (result == WIDTH'(opnd_a + opnd_b)) // R1
                else $error("add result wrong");
        end
        if (op == OP_SUB) begin
            AST_SUB_DIFF: assert (result == WIDTH'(opnd_a - opnd_b)) // R2
                else $error("subtract result wrong");
            AST_NO_BORROW: assert (carry_out == (opnd_a >= opnd_b)) // R6
                else $error("subtract carry wrong");
        end
        if (op == OP_AND || op == OP_OR) begin
            AST_LOGIC_FLAGS_LOW: assert (!carry_out && !overflow) // R9
                else $error("flags set on logic op");
        end
    end

endmodule

// File: tb/alu4_ripple_tb.sv
module alu4_ripple_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] a32, b32, r32;
    logic [1:0]  op32;
    logic        c32, v32;
    logic [3:0]  a4, b4, r4;
    logic [1:0]  op4;
    logic        c4, v4;

    alu4_ripple #(.WIDTH(32)) u_dut (
        .opnd_a (a32), .opnd_b (b32), .op_sel (op32),
        .result (r32), .carry_out (c32), .overflow (v32)
    );

    alu4_ripple #(.WIDTH(4)) u_dut4 (
        .opnd_a (a4), .opnd_b (b4), .op_sel (op4),
        .result (r4), .carry_out (c4), .overflow (v4)
    );

    function automatic void model32(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                                    output logic [31:0] r, output logic c, output logic v);
        case (op)
            2'b00: begin {c, r} = {1'b0, a} + {1'b0, b}; v = (a[31] == b[31]) && (r[31] != a[31]); end
            2'b01: begin {c, r} = {1'b0, a} + {1'b0, ~b} + 33'd1; v = (a[31] != b[31]) && (r[31] != a[31]); end
            2'b10: begin r = a & b; c = 1'b0; v = 1'b0; end
            default: begin r = a | b; c = 1'b0; v = 1'b0; end
        endcase
    endfunction

    function automatic void model4(input logic [3:0] a, input logic [3:0] b, input logic [1:0] op,
                                   output logic [3:0] r, output logic c, output logic v);
        case (op)
            2'b00: begin {c, r} = {1'b0, a} + {1'b0, b}; v = (a[3] == b[3]) && (r[3] != a[3]); end
            2'b01: begin {c, r} = {1'b0, a} + {1'b0, ~b} + 5'd1; v = (a[3] != b[3]) && (r[3] != a[3]); end
            2'b10: begin r = a & b; c = 1'b0; v = 1'b0; end
            default: begin r = a | b; c = 1'b0; v = 1'b0; end
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] op);
        case (op)
            2'b00:   return "R1 R5 R7";
            2'b01:   return "R2 R6 R8";
            2'b10:   return "R3 R9";
            default: return "R4 R9";
        endcase
    endfunction

    task automatic chk32(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                         input logic [31:0] er, input logic ec, input logic ev, input string tag);
        @(posedge clk);
        a32 = a; b32 = b; op32 = op;
        @(negedge clk);
        n_cmp++;
        if (r32 !== er || c32 !== ec || v32 !== ev) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h op=%0d got r=%h c=%b v=%b expected r=%h c=%b v=%b",
                     tag, a, b, op, r32, c32, v32, er, ec, ev);
        end
    endtask

    task automatic chk4(input logic [3:0] a, input logic [3:0] b, input logic [1:0] op, output bit bad);
        logic [3:0] er;
        logic       ec, ev;
        model4(a, b, op, er, ec, ev);
        a4 = a; b4 = b; op4 = op;
        #1;
        bad = (r4 !== er || c4 !== ec || v4 !== ev);
        if (bad)
            $display("FAIL %s (width 4): a=%h b=%h op=%0d got r=%h c=%b v=%b expected r=%h c=%b v=%b",
                     tag_of(op), a, b, op, r4, c4, v4, er, ec, ev);
    endtask

    task automatic t_zero();
        chk32(32'h0, 32'h0, 2'b00, 32'h0, 1'b0, 1'b0, "R1 zero operands");
        chk32(32'h0, 32'h0, 2'b01, 32'h0, 1'b1, 1'b0, "R6 zero minus zero");
    endtask

    task automatic t_add_corners();
        chk32(32'h7FFFFFFF, 32'h1, 2'b00, 32'h80000000, 1'b0, 1'b1, "R10 R7 positive wrap");
        chk32(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b00, 32'hFFFFFFFE, 1'b1, 1'b0, "R10 R5 carry without overflow");
        chk32(32'h80000000, 32'h80000000, 2'b00, 32'h0, 1'b1, 1'b1, "R7 negative wrap");
        chk32(32'h12345678, 32'h11111111, 2'b00, 32'h23456789, 1'b0, 1'b0, "R1 plain add");
    endtask

    task automatic t_sub_corners();
        chk32(32'h0, 32'h1, 2'b01, 32'hFFFFFFFF, 1'b0, 1'b0, "R2 R6 borrow");
        chk32(32'h80000000, 32'h1, 2'b01, 32'h7FFFFFFF, 1'b1, 1'b1, "R8 negative minus positive");
        chk32(32'h7FFFFFFF, 32'hFFFFFFFF, 2'b01, 32'h80000000, 1'b0, 1'b1, "R8 positive minus negative");
        chk32(32'h5, 32'h5, 2'b01, 32'h0, 1'b1, 1'b0, "R6 equal operands");
    endtask

    task automatic t_logic();
        chk32(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b10, 32'hFFFFFFFF, 1'b0, 1'b0, "R3 R9 all ones AND");
        chk32(32'hF0F0A5A5, 32'h0FF05AFF, 2'b10, 32'h00F000A5, 1'b0, 1'b0, "R3 pattern AND");
        chk32(32'hF0F0A5A5, 32'h0FF05AFF, 2'b11, 32'hFFF0FFFF, 1'b0, 1'b0, "R4 pattern OR");
        chk32(32'h80000000, 32'h80000000, 2'b11, 32'h80000000, 1'b0, 1'b0, "R4 R9 sign bits OR");
    endtask

    task automatic t_random32();
        logic [31:0] a, b, er;
        logic        ec, ev;
        logic [1:0]  op;
        for (int i = 0; i < 400; i++) begin
            a  = $urandom();
            b  = $urandom();
            op = 2'($urandom());
            if (i % 8 == 0) b = a;
            if (i % 8 == 1) b = ~a;
            model32(a, b, op, er, ec, ev);
            chk32(a, b, op, er, ec, ev, tag_of(op));
        end
    endtask

    task automatic t_exhaustive4();
        bit bad;
        @(negedge clk);
        for (int op = 0; op < 4; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    chk4(4'(a), 4'(b), 2'(op), bad);
                    n_cmp++;
                    if (bad) n_bad++;
                end
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        a32 = '0; b32 = '0; op32 = 2'b00;
        a4  = '0; b4  = '0; op4  = 2'b00;
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        t_zero();
        t_add_corners();
        t_sub_corners();
        t_logic();
        t_random32();
        t_exhaustive4();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got no completion, expected completion");
        finish_run();
    end

endmodule